// File: doc/BRIEF.md
# Endpoint Ready and Completion Status

This block keeps two status bits per endpoint direction for a four-endpoint USB device controller: one that says a buffer is primed and ready, and one that records that a transfer finished. Each endpoint has a transmit and a receive direction, so the block tracks eight channels. Prime requests do not take effect at once. They queue in a pending mask, and a small scheduler serves them one at a time, lowest endpoint first and receive before transmit within an endpoint. Each service waits a programmable number of cycles before its ready bit sets, so priming more channels at once makes the last one ready later.

Ready bits drop on a bus reset, on a clear from the DMA side or on a flush. While a descriptor is retired and the channel re-primes, the ready bit reads as zero for a fixed window and then reads as set again. Completion pulses from the DMA engine set completion bits. Software clears a completion bit by writing a one to it. When a completion pulse carries the interrupt-on-complete flag, the completion bit and the USB interrupt rise together. The interrupt stays high until every completion bit that was raised with that flag has been cleared.

The scheduler has three states. SCH_IDLE moves to SCH_WAIT when any prime is pending; on that edge it latches the lowest pending channel and loads the delay counter. SCH_WAIT counts down and moves to SCH_GRANT when the counter reads zero. SCH_GRANT sets the channel's ready bit, unless the channel was cleared or cancelled meanwhile, and returns to SCH_IDLE. Each channel also has a hide timer with two states. HIDE_OFF moves to HIDE_ON on a retire event. HIDE_ON moves back to HIDE_OFF once its counter runs out, and a new retire event in HIDE_ON restarts the count.

Top module: `ep_ready_status`

## Requirements
- R1: Reset state: all ready bits, completion bits and `usb_int` are 0. In the status word (address 0), transmit-ready of endpoint e is bit 16+e and receive-ready of endpoint e is bit e. All other bits read 0.
- R2: A prime for a single channel, sampled at clock edge T while the scheduler is idle, sets that channel's ready bit at edge T+D+3, where D is `prime_delay`. The bit reads 0 before that edge.
- R3: Primes that are pending together are served one at a time in the order receive ep0, transmit ep0, receive ep1, … transmit ep3. The k-th channel served (counting from 1) becomes ready at edge T+k·(D+3).
- R4: `bus_reset` clears every ready bit. A flush or a DMA clear for one endpoint and direction clears that ready bit only. Each of these also cancels a pending prime for the channels it affects.
- R5: A flush that arrives on the same edge as the scheduler's ready-set cancels the set, and the bit stays 0.
- R6: A retire event for a ready channel at edge T makes its status bit read 0 after edges T through T+HIDE_CYC−1. The bit reads 1 again after edge T+HIDE_CYC.
- R7: In the completion word (address 1), transmit-complete of endpoint e is bit 16+e and receive-complete of endpoint e is bit e. A completion pulse sets the bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If a completion pulse and a write-one-to-clear hit the same bit on the same edge, the bit stays set.
- R9: A completion pulse with `xfer_ioc`=1 raises the completion bit and `usb_int` on the same edge. With `xfer_ioc`=0 only the completion bit rises.
- R10: `usb_int` stays 1 while any completion bit raised with `xfer_ioc`=1 is still set. It falls on the edge that clears the last such bit.
- R11: Writes to the status word have no effect on any bit. Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prime_tx | input | 4 | Prime request per endpoint, transmit side |
| prime_rx | input | 4 | Prime request per endpoint, receive side |
| prime_delay | input | 4 | Wait cycles added to each prime service |
| flush_tx | input | 4 | Flush per endpoint, transmit side |
| flush_rx | input | 4 | Flush per endpoint, receive side |
| dma_clr_tx | input | 4 | DMA-side ready clear, transmit side |
| dma_clr_rx | input | 4 | DMA-side ready clear, receive side |
| bus_reset | input | 1 | USB bus reset, clears all ready bits |
| retire_tx | input | 4 | Descriptor retire and re-prime event, transmit side |
| retire_rx | input | 4 | Descriptor retire and re-prime event, receive side |
| xfer_done_tx | input | 4 | Transfer-complete pulse, transmit side |
| xfer_done_rx | input | 4 | Transfer-complete pulse, receive side |
| xfer_ioc | input | 1 | Interrupt-on-complete flag for this cycle's completion pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| usb_int | output | 1 | USB interrupt status |

## Verification
On every cycle the assertions check these rules. A ready bit can rise only on a channel that had a pending prime, and any clear source empties that ready bit on the next edge. The wait counter counts down by exactly one per cycle, and the scheduler always picks the lowest pending channel. A retire event always opens the hide window, and a completion pulse always leaves its bit set, together with the interrupt when the flag is on. Only the bench scenarios can show the arithmetic timing. That covers the exact ready edge for every one of the 255 prime masks and the position of each channel in the service order. It also covers the length of the hide window, the race between a flush and a grant, and the order in which the interrupt falls as bits are cleared.

// File: rtl/epst_pkg.sv
package epst_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_WAIT  = 2'd1,
        SCH_GRANT = 2'd2
    } sched_state_t;

    typedef enum logic {
        HIDE_OFF = 1'b0,
        HIDE_ON  = 1'b1
    } hide_state_t;

    // Channel numbering: receive of endpoint e is 2e, transmit is 2e+1.
    // The scheduler serves channels in ascending number.
    function automatic int unsigned chan_index(input int unsigned ep, input bit is_tx);
        return ep * 2 + (is_tx ? 1 : 0);
    endfunction

endpackage

// File: rtl/epst_prime_sched.sv
module epst_prime_sched
    import epst_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   prime_req,
    input  logic [NCH-1:0]   kill,
    input  logic [DLY_W-1:0] delay_len,
    output logic             grant_vld,
    output logic [CH_W-1:0]  grant_chan,
    output logic [NCH-1:0]   pend_o
);

    sched_state_t     state_q, state_d;
    logic [NCH-1:0]   pend_q, pend_d;
    logic [CH_W-1:0]  chan_q;
    logic [DLY_W-1:0] cnt_q;
    logic [CH_W-1:0]  pick;
    logic             pick_vld;
    logic [NCH-1:0]   served;
    logic [NCH-1:0]   lo_mask;

    // lowest pending channel wins
    always_comb begin
        pick     = '0;
        pick_vld = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                pick     = CH_W'(i);
                pick_vld = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_IDLE:  if (pick_vld)        state_d = SCH_WAIT;
            SCH_WAIT:  if (cnt_q == '0)     state_d = SCH_GRANT;
            SCH_GRANT:                      state_d = SCH_IDLE;
            default:                        state_d = SCH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant_vld = 1'b0;
        served    = '0;
        unique case (state_q)
            SCH_GRANT: begin
                grant_vld = pend_q[chan_q] & ~kill[chan_q];
                served    = NCH'(1) << chan_q;
            end
            SCH_IDLE, SCH_WAIT: ;
            default: ;
        endcase
    end

    assign grant_chan = chan_q;
    assign pend_o     = pend_q;

    // a clear source cancels a queued prime as well
    assign pend_d = ((pend_q & ~served) | prime_req) & ~kill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            chan_q <= '0;
            cnt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            if (state_q == SCH_IDLE && pick_vld) begin
                chan_q <= pick;
                cnt_q  <= delay_len;
            end else if (state_q == SCH_WAIT && cnt_q != '0) begin
                cnt_q  <= cnt_q - DLY_W'(1);
            end
        end
    end

    assign lo_mask = (NCH'(1) << chan_q) - NCH'(1);

    assert_wait_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_WAIT && cnt_q != '0) |=>
            (state_q == SCH_WAIT && cnt_q == $past(cnt_q) - DLY_W'(1)))
        else $error("wait counter did not step down by one");

    assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_IDLE && pick_vld) |=>
            (state_q == SCH_WAIT && ($past(pend_q) & lo_mask) == '0))
        else $error("scheduler skipped a lower pending channel");

endmodule

// File: rtl/epst_hide_window.sv
module epst_hide_window
    import epst_pkg::*;
#(
    parameter int HIDE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic hide_o
);

    localparam int CW = (HIDE_CYC > 1) ? $clog2(HIDE_CYC) : 1;

    hide_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HIDE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIDE_OFF: if (start)                  state_d = HIDE_ON;
            HIDE_ON:  if (!start && cnt_q == '0)  state_d = HIDE_OFF;
            default:                              state_d = HIDE_OFF;
        endcase
    end

    always_comb begin
        hide_o = 1'b0;
        unique case (state_q)
            HIDE_ON:  hide_o = 1'b1;
            HIDE_OFF: hide_o = 1'b0;
            default:  hide_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CW'(HIDE_CYC - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assert_retire_hides_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> hide_o)
        else $error("retire event did not open the hide window");

endmodule

// File: rtl/epst_done_bank.sv
module epst_done_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic           evt_ioc,
    input  logic [NCH-1:0] w1c,
    output logic [NCH-1:0] done_o,
    output logic           int_o
);

    logic [NCH-1:0] done_q;
    logic [NCH-1:0] tag_q;

    // event beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            tag_q  <= '0;
        end else begin
            done_q <= (done_q & ~w1c) | evt;
            tag_q  <= (tag_q & ~w1c) | (evt & {NCH{evt_ioc}});
        end
    end

    assign done_o = done_q;
    assign int_o  = |tag_q;

    assert_int_has_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (done_q != '0))
        else $error("interrupt high with no completion bit set");

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> done_q[i])
            else $error("completion bit %0d lost its event", i);

        assert_ioc_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && evt_ioc) |=> (done_q[i] && int_o))
            else $error("completion bit %0d and interrupt not raised together", i);
    end

endmodule

// File: rtl/ep_ready_status.sv
module ep_ready_status
    import epst_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int DATA_W    = 32,
    parameter int TX_LSB    = 16,
    parameter int RX_LSB    = 0,
    parameter int ADDR_W    = 2,
    parameter int STAT_ADDR = 0,
    parameter int DONE_ADDR = 1,
    parameter int DLY_W     = 4,
    parameter int HIDE_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] prime_tx,
    input  logic [NUM_EP-1:0] prime_rx,
    input  logic [DLY_W-1:0]  prime_delay,
    input  logic [NUM_EP-1:0] flush_tx,
    input  logic [NUM_EP-1:0] flush_rx,
    input  logic [NUM_EP-1:0] dma_clr_tx,
    input  logic [NUM_EP-1:0] dma_clr_rx,
    input  logic              bus_reset,
    input  logic [NUM_EP-1:0] retire_tx,
    input  logic [NUM_EP-1:0] retire_rx,
    input  logic [NUM_EP-1:0] xfer_done_tx,
    input  logic [NUM_EP-1:0] xfer_done_rx,
    input  logic              xfer_ioc,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              usb_int
);

    localparam int NCH  = 2 * NUM_EP;
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0]  prime_ch, kill_ch, retire_ch, evt_ch, w1c_ch;
    logic [NCH-1:0]  ready_q, set_vec, hide_ch, vis_ch, done_ch, pend_ch;
    logic            grant_vld;
    logic [CH_W-1:0] grant_chan;
    logic            done_wr;
    logic            unused_wdata;

    assign done_wr      = reg_wr && (reg_addr == ADDR_W'(DONE_ADDR));
    assign unused_wdata = ^reg_wdata;

    // fold per-direction masks onto channel numbers
    for (genvar e = 0; e < NUM_EP; e++) begin : g_map
        localparam int CR = chan_index(e, 1'b0);
        localparam int CT = chan_index(e, 1'b1);
        assign prime_ch[CR]  = prime_rx[e];
        assign prime_ch[CT]  = prime_tx[e];
        assign kill_ch[CR]   = bus_reset | flush_rx[e] | dma_clr_rx[e];
        assign kill_ch[CT]   = bus_reset | flush_tx[e] | dma_clr_tx[e];
        assign retire_ch[CR] = retire_rx[e];
        assign retire_ch[CT] = retire_tx[e];
        assign evt_ch[CR]    = xfer_done_rx[e];
        assign evt_ch[CT]    = xfer_done_tx[e];
        assign w1c_ch[CR]    = done_wr & reg_wdata[RX_LSB + e];
        assign w1c_ch[CT]    = done_wr & reg_wdata[TX_LSB + e];
    end

    epst_prime_sched #(
        .NCH   (NCH),
        .CH_W  (CH_W),
        .DLY_W (DLY_W)
    ) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .prime_req  (prime_ch),
        .kill       (kill_ch),
        .delay_len  (prime_delay),
        .grant_vld  (grant_vld),
        .grant_chan (grant_chan),
        .pend_o     (pend_ch)
    );

    assign set_vec = grant_vld ? (NCH'(1) << grant_chan) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= (ready_q | set_vec) & ~kill_ch;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_hide
        epst_hide_window #(
            .HIDE_CYC (HIDE_CYC)
        ) u_hide (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (retire_ch[c]),
            .hide_o (hide_ch[c])
        );

        assert_ready_needs_prime_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ready_q[c] && !$past(ready_q[c])) |-> $past(pend_ch[c]))
            else $error("ready bit %0d rose without a pending prime", c);

        assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            kill_ch[c] |=> !ready_q[c])
            else $error("ready bit %0d survived a clear", c);
    end

    assign vis_ch = ready_q & ~hide_ch;

    epst_done_bank #(
        .NCH (NCH)
    ) u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_ch),
        .evt_ioc (xfer_ioc),
        .w1c     (w1c_ch),
        .done_o  (done_ch),
        .int_o   (usb_int)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(STAT_ADDR)) begin
            for (int e = 0; e < NUM_EP; e++) begin
                reg_rdata[RX_LSB + e] = vis_ch[2 * e];
                reg_rdata[TX_LSB + e] = vis_ch[2 * e + 1];
            end
        end else if (reg_addr == ADDR_W'(DONE_ADDR)) begin
            for (int e = 0; e < NUM_EP; e++) begin
                reg_rdata[RX_LSB + e] = done_ch[2 * e];
                reg_rdata[TX_LSB + e] = done_ch[2 * e + 1];
            end
        end
    end

endmodule

// File: tb/ep_ready_status_bench.sv
`timescale 1ns/1ps
module ep_ready_status_bench;

    localparam int D     = 2;
    localparam int P     = D + 3;
    localparam int W     = 3;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  prime_tx, prime_rx, flush_tx, flush_rx, dma_clr_tx, dma_clr_rx;
    logic [3:0]  retire_tx, retire_rx, xfer_done_tx, xfer_done_rx;
    logic [3:0]  prime_delay;
    logic        bus_reset, xfer_ioc, reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        usb_int;

    int nvec = 0;
    int nerr = 0;
    int cyc  = 0;

    always #2.5 clk = ~clk;

    ep_ready_status #(.HIDE_CYC(W)) u_ep_ready_status (
        .clk(clk), .rst_n(rst_n),
        .prime_tx(prime_tx), .prime_rx(prime_rx), .prime_delay(prime_delay),
        .flush_tx(flush_tx), .flush_rx(flush_rx),
        .dma_clr_tx(dma_clr_tx), .dma_clr_rx(dma_clr_rx),
        .bus_reset(bus_reset), .retire_tx(retire_tx), .retire_rx(retire_rx),
        .xfer_done_tx(xfer_done_tx), .xfer_done_rx(xfer_done_rx), .xfer_ioc(xfer_ioc),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .usb_int(usb_int)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            nerr++;
            $display("FAIL watchdog got timeout expected completion before %0d cycles", LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    // channel 2e = receive ep e (bit e), channel 2e+1 = transmit ep e (bit 16+e)
    function automatic logic [31:0] word_of(input logic [7:0] ch);
        logic [31:0] w = '0;
        for (int e = 0; e < 4; e++) begin
            w[e]      = ch[2 * e];
            w[16 + e] = ch[2 * e + 1];
        end
        return w;
    endfunction

    function automatic logic [3:0] rx_of(input logic [7:0] ch);
        return {ch[6], ch[4], ch[2], ch[0]};
    endfunction

    function automatic logic [3:0] tx_of(input logic [7:0] ch);
        return {ch[7], ch[5], ch[3], ch[1]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse_prime(input logic [7:0] ch);
        @(negedge clk);
        prime_rx = rx_of(ch);
        prime_tx = tx_of(ch);
        @(negedge clk);
        prime_rx = '0;
        prime_tx = '0;
    endtask

    task automatic done_cycle(input logic [7:0] ch, input logic ioc,
                              input logic wr, input logic [31:0] wd);
        @(negedge clk);
        xfer_done_rx = rx_of(ch);
        xfer_done_tx = tx_of(ch);
        xfer_ioc     = ioc;
        reg_wr       = wr;
        reg_addr     = 2'd1;
        reg_wdata    = wd;
        @(negedge clk);
        xfer_done_rx = '0;
        xfer_done_tx = '0;
        xfer_ioc     = 1'b0;
        reg_wr       = 1'b0;
    endtask

    task automatic fill_all();
        pulse_prime(8'hFF);
        repeat (8 * P + 2) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0]  exp_ch;
        int          rank;

        prime_tx = '0; prime_rx = '0; flush_tx = '0; flush_rx = '0;
        dma_clr_tx = '0; dma_clr_rx = '0; retire_tx = '0; retire_rx = '0;
        xfer_done_tx = '0; xfer_done_rx = '0; xfer_ioc = 1'b0; bus_reset = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; prime_delay = 4'(D);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(2'd0, v); check("R1 status after reset", v, 32'h0);
        rd(2'd1, v); check("R1 completion after reset", v, 32'h0);
        check("R1 usb_int after reset", {31'b0, usb_int}, 32'h0);
        rd(2'd2, v); check("R11 address 2 reads zero", v, 32'h0);
        rd(2'd3, v); check("R11 address 3 reads zero", v, 32'h0);

        // R2/R3: every prime mask, each cycle compared against rank*(D+3)
        for (int m = 1; m < 256; m++) begin
            pulse_prime(8'(m));
            for (int j = 0; j <= $countones(8'(m)) * P + 1; j++) begin
                exp_ch = '0;
                rank   = 0;
                for (int c = 0; c < 8; c++) begin
                    if (m[c]) begin
                        rank++;
                        if (j >= rank * P) exp_ch[c] = 1'b1;
                    end
                end
                rd(2'd0, v);
                check((j < P) ? "R2 prime delay" : "R3 service order", v, word_of(exp_ch));
                @(negedge clk);
            end
            bus_reset = 1'b1;
            @(negedge clk);
            bus_reset = 1'b0;
            repeat (P + 2) @(negedge clk);
            rd(2'd0, v); check("R4 bus reset clears all", v, 32'h0);
        end

        // R5: flush on the grant edge cancels the set (rx ep2 = ch4, tx ep0 = ch1)
        for (int k = 0; k < 2; k++) begin
            exp_ch = (k == 0) ? 8'h10 : 8'h02;
            pulse_prime(exp_ch);
            for (int j = 0; j < P; j++) begin
                rd(2'd0, v); check("R5 before grant", v, 32'h0);
                if (j == P - 1) begin
                    flush_rx = rx_of(exp_ch);
                    flush_tx = tx_of(exp_ch);
                end
                @(negedge clk);
            end
            flush_rx = '0; flush_tx = '0;
            rd(2'd0, v); check("R5 flush cancels grant", v, 32'h0);
            repeat (P + 2) @(negedge clk);
            rd(2'd0, v); check("R5 stays clear", v, 32'h0);
        end

        // R4: flush cancels a queued prime (tx ep3 = ch7)
        pulse_prime(8'h80);
        flush_tx = 4'b1000;
        @(negedge clk);
        flush_tx = '0;
        repeat (2 * P) @(negedge clk);
        rd(2'd0, v); check("R4 flush cancels pending", v, 32'h0);

        // R4: single-channel clears
        fill_all();
        rd(2'd0, v); check("R3 all channels ready", v, 32'h000F000F);
        @(negedge clk); flush_tx = 4'b0010;
        @(negedge clk); flush_tx = '0;
        rd(2'd0, v); check("R4 flush tx ep1", v, word_of(8'hF7));
        @(negedge clk); dma_clr_rx = 4'b1000;
        @(negedge clk); dma_clr_rx = '0;
        rd(2'd0, v); check("R4 dma clear rx ep3", v, word_of(8'hB7));
        pulse_prime(8'h48);
        repeat (2 * P + 2) @(negedge clk);
        rd(2'd0, v); check("R3 refill", v, 32'h000F000F);

        // R6: retire on tx ep2 (ch5) hides W cycles
        @(negedge clk); retire_tx = 4'b0100;
        @(negedge clk); retire_tx = '0;
        for (int j = 0; j < W; j++) begin
            rd(2'd0, v); check("R6 hidden during re-prime", v, word_of(8'hDF));
            @(negedge clk);
        end
        rd(2'd0, v); check("R6 returns set", v, 32'h000F000F);

        // R11: status writes ignored
        @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'hFFFFFFFF;
        @(negedge clk); reg_wdata = 32'h0;
        @(negedge clk); reg_wr = 1'b0;
        rd(2'd0, v); check("R11 status write ignored", v, 32'h000F000F);
        rd(2'd1, v); check("R11 completion untouched", v, 32'h0);

        // R7/R9/R10: each channel, with and without the interrupt flag
        for (int c = 0; c < 8; c++) begin
            for (int ioc = 0; ioc < 2; ioc++) begin
                exp_ch = 8'(1 << c);
                done_cycle(exp_ch, 1'(ioc), 1'b0, 32'h0);
                rd(2'd1, v); check("R7 completion set", v, word_of(exp_ch));
                check("R9 interrupt with completion", {31'b0, usb_int}, 32'(ioc));
                done_cycle(8'h00, 1'b0, 1'b1, 32'h0);
                rd(2'd1, v); check("R7 write zero keeps bit", v, word_of(exp_ch));
                check("R10 interrupt held", {31'b0, usb_int}, 32'(ioc));
                done_cycle(8'h00, 1'b0, 1'b1, word_of(exp_ch));
                rd(2'd1, v); check("R7 write one clears", v, 32'h0);
                check("R10 interrupt drops", {31'b0, usb_int}, 32'h0);
            end
        end

        // R8: event and clear on the same edge (tx ep2 = ch5)
        done_cycle(8'h20, 1'b0, 1'b0, 32'h0);
        done_cycle(8'h20, 1'b1, 1'b1, word_of(8'h20));
        rd(2'd1, v); check("R8 event beats clear", v, word_of(8'h20));
        check("R8 interrupt raised", {31'b0, usb_int}, 32'h1);
        done_cycle(8'h00, 1'b0, 1'b1, word_of(8'h20));

        // R10: interrupt held by the last flagged bit
        done_cycle(8'h02, 1'b1, 1'b0, 32'h0);
        done_cycle(8'h40, 1'b1, 1'b0, 32'h0);
        done_cycle(8'h04, 1'b0, 1'b0, 32'h0);
        rd(2'd1, v); check("R7 three bits set", v, word_of(8'h46));
        done_cycle(8'h00, 1'b0, 1'b1, word_of(8'h02));
        check("R10 one flagged bit left", {31'b0, usb_int}, 32'h1);
        done_cycle(8'h00, 1'b0, 1'b1, word_of(8'h40));
        check("R10 no flagged bit left", {31'b0, usb_int}, 32'h0);
        rd(2'd1, v); check("R10 unflagged bit remains", v, word_of(8'h04));
        done_cycle(8'h00, 1'b0, 1'b1, word_of(8'h04));
        rd(2'd1, v); check("R7 all cleared", v, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule